// File: doc/BRIEF.md
# Chip-Select Bus Access Sequencer

This block runs one read or write access at a time on a single region of a parallel external bus, such as a removable flash card wired in memory or I/O mode. A host hands over an address, a direction and, for writes, a data word through a ready/valid handshake. The block then drives the address and the active-low chip enable, output enable and write enable through a fixed order of phases. For reads it returns the sampled data with a one-cycle done pulse.

Every phase length comes from a timing input that holds the wanted count minus one. That count is then scaled by a per-region multiplier. An optional wait mode lets a slow device stretch the strobe by holding its IORDY line low. A region-enable input can retire a request at once without touching the bus.

Top module: `cs_bus_seq`

## Requirements
- R1: With timing field value f and multiplier m, a phase lasts (f+1)*m clock cycles. A multiplier of 0 acts as 1. This applies to the address-setup, CE-to-strobe, strobe, hold and pause phases.
- R2: The order is: address setup with CE high, then CE low with both strobes high, then the strobe low, then hold with CE low and the strobe high, then pause with CE high. The address stays constant from acceptance to the end of the access.
- R3: A read uses the output-enable strobe and its own field. The read data is sampled on the clock edge that ends the strobe. rsp_done_o pulses for one cycle, in the first hold cycle, with the data on rsp_rdata_o.
- R4: A write uses the write-enable strobe and its own field. The write data is driven with bus_data_oe_o high from the first setup cycle through the last hold cycle, and bus_oe_no stays high throughout. rsp_done_o pulses in the first hold cycle.
- R5: The hold phase uses the read-hold field for reads and the write-hold field for writes.
- R6: req_ready_o is high only when the sequencer is idle. It stays low through every phase, including pause, so a new request is held off until the pause has elapsed.
- R7: With wait mode on, the strobe stays low past its programmed count for as long as IORDY is sampled low. After IORDY is sampled high, it stays low for a further WAIT*m cycles. WAIT = 0 adds none.
- R8: With wait mode off, IORDY has no effect: the strobe lasts exactly its programmed count.
- R9: A request while the region is disabled is accepted at once. rsp_done_o pulses in the next cycle with rsp_rdata_o = 0. CE, OE and WE stay high.
- R10: After reset: CE, OE and WE are high, bus_data_oe_o and rsp_done_o are low, and req_ready_o is high.
- R11: OE and WE are never low together, and either is low only while CE is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Sequencer idle, request accepted when valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Access address |
| req_wdata_i | input | DW | Write data |
| cfg_en_i | input | 1 | Region enable |
| cfg_mult_i | input | MW | Timing multiplier (0 acts as 1) |
| cfg_adr_i | input | TW | Address-setup count minus one |
| cfg_ce_i | input | TW | CE-to-strobe count minus one |
| cfg_oe_i | input | TW | Read strobe count minus one |
| cfg_we_i | input | TW | Write strobe count minus one |
| cfg_rdhld_i | input | TW | Read hold count minus one |
| cfg_wrhld_i | input | TW | Write hold count minus one |
| cfg_pause_i | input | TW | Pause count minus one |
| cfg_waitm_i | input | 1 | Wait mode: IORDY stretches strobe |
| cfg_wait_i | input | TW | Extra strobe periods after IORDY returns |
| bus_addr_o | output | AW | Bus address |
| bus_ce_no | output | 1 | Chip enable, active low |
| bus_oe_no | output | 1 | Output enable, active low |
| bus_we_no | output | 1 | Write enable, active low |
| bus_data_i | input | DW | Bus data in |
| bus_data_o | output | DW | Bus data out |
| bus_data_oe_o | output | 1 | Bus data driver enable |
| bus_iordy_i | input | 1 | Device ready, low stretches strobe |
| rsp_done_o | output | 1 | Access completion pulse |
| rsp_rdata_o | output | DW | Read data |

## Verification
The assertions check the signal relations that must hold on every cycle:
- strobes are exclusive and only occur under CE;
- CE and ready never overlap;
- the address is stable across CE;
- the data driver tracks the strobe type;
- a disabled access finishes next cycle without CE.

Only the bench's scenarios can show the per-phase cycle counts under different fields and multipliers, and the choice of hold field by direction. The same goes for read sampling exactly at strobe end, since the bench changes the bus data right after. IORDY stretching by an exact amount, plus WAIT extension, and the absence of any effect with wait mode off are likewise left to directed scenarios.

// File: rtl/cs_seq_pkg.sv
`timescale 1ns/1ps
package cs_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_ADR, PH_CES, PH_STB, PH_WEXT, PH_HLD, PH_PAU
  } phase_e;
endpackage

// File: rtl/cs_phase_len.sv
`timescale 1ns/1ps
module cs_phase_len #(
  parameter int TW = 6,
  parameter int MW = 3,
  localparam int CW = TW + MW
) (
  input  logic [TW-1:0] field_i,
  input  logic          plus_one_i,
  input  logic [MW-1:0] mult_i,
  output logic [CW-1:0] len_m1_o
);
  logic [CW-1:0] base, mult_eff, prod;
  always_comb begin
    base     = CW'(field_i) + CW'(plus_one_i);
    mult_eff = (mult_i == '0) ? CW'(1) : CW'(mult_i);
    prod     = base * mult_eff;
    len_m1_o = prod - CW'(1);
  end
endmodule

// File: rtl/cs_scale_timer.sv
`timescale 1ns/1ps
module cs_scale_timer #(
  parameter int CW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/cs_seq_ctrl.sv
`timescale 1ns/1ps
module cs_seq_ctrl
  import cs_seq_pkg::*;
#(
  parameter int TW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic          cfg_en_i,
  input  logic [TW-1:0] cfg_adr_i,
  input  logic [TW-1:0] cfg_ce_i,
  input  logic [TW-1:0] cfg_oe_i,
  input  logic [TW-1:0] cfg_we_i,
  input  logic [TW-1:0] cfg_rdhld_i,
  input  logic [TW-1:0] cfg_wrhld_i,
  input  logic [TW-1:0] cfg_pause_i,
  input  logic          cfg_waitm_i,
  input  logic [TW-1:0] cfg_wait_i,
  input  logic          iordy_i,
  input  logic          zero_i,
  output phase_e        phase_o,
  output logic          wr_o,
  output logic          load_o,
  output logic [TW-1:0] field_o,
  output logic          plus_one_o,
  output logic          accept_o,
  output logic          skip_o,
  output logic          strobe_end_o
);
  phase_e ph_q, ph_d;
  logic   wr_q;

  always_comb begin
    ph_d       = ph_q;
    load_o     = 1'b0;
    field_o    = '0;
    plus_one_o = 1'b1;
    unique case (ph_q)
      PH_IDLE: if (req_valid_i && cfg_en_i) begin
        ph_d = PH_ADR; load_o = 1'b1; field_o = cfg_adr_i;
      end
      PH_ADR: if (zero_i) begin
        ph_d = PH_CES; load_o = 1'b1; field_o = cfg_ce_i;
      end
      PH_CES: if (zero_i) begin
        ph_d = PH_STB; load_o = 1'b1; field_o = wr_q ? cfg_we_i : cfg_oe_i;
      end
      PH_STB: if (zero_i && !(cfg_waitm_i && !iordy_i)) begin
        load_o = 1'b1;
        if (cfg_waitm_i && cfg_wait_i != '0) begin
          ph_d = PH_WEXT; field_o = cfg_wait_i; plus_one_o = 1'b0;
        end else begin
          ph_d = PH_HLD; field_o = wr_q ? cfg_wrhld_i : cfg_rdhld_i;
        end
      end
      PH_WEXT: if (zero_i) begin
        ph_d = PH_HLD; load_o = 1'b1; field_o = wr_q ? cfg_wrhld_i : cfg_rdhld_i;
      end
      PH_HLD: if (zero_i) begin
        ph_d = PH_PAU; load_o = 1'b1; field_o = cfg_pause_i;
      end
      PH_PAU: if (zero_i) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  assign accept_o     = (ph_q == PH_IDLE) && req_valid_i;
  assign skip_o       = accept_o && !cfg_en_i;
  assign strobe_end_o = (ph_q == PH_STB || ph_q == PH_WEXT) && ph_d == PH_HLD;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= PH_IDLE;
      wr_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (accept_o) wr_q <= req_write_i;
    end
  end

  assign phase_o = ph_q;
  assign wr_o    = wr_q;
endmodule

// File: rtl/cs_data_path.sv
`timescale 1ns/1ps
module cs_data_path #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          skip_i,
  input  logic          strobe_end_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] bus_data_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o,
  output logic          done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
      rdata_o <= '0;
      done_o  <= 1'b0;
    end else begin
      if (accept_i) begin
        addr_o  <= addr_i;
        wdata_o <= wdata_i;
      end
      if (skip_i)                     rdata_o <= '0;
      else if (strobe_end_i && !wr_i) rdata_o <= bus_data_i;
      done_o <= skip_i || strobe_end_i;
    end
  end
endmodule

// File: rtl/cs_bus_seq.sv
`timescale 1ns/1ps
module cs_bus_seq
  import cs_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int TW = 6,
  parameter int MW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          cfg_en_i,
  input  logic [MW-1:0] cfg_mult_i,
  input  logic [TW-1:0] cfg_adr_i,
  input  logic [TW-1:0] cfg_ce_i,
  input  logic [TW-1:0] cfg_oe_i,
  input  logic [TW-1:0] cfg_we_i,
  input  logic [TW-1:0] cfg_rdhld_i,
  input  logic [TW-1:0] cfg_wrhld_i,
  input  logic [TW-1:0] cfg_pause_i,
  input  logic          cfg_waitm_i,
  input  logic [TW-1:0] cfg_wait_i,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_ce_no,
  output logic          bus_oe_no,
  output logic          bus_we_no,
  input  logic [DW-1:0] bus_data_i,
  output logic [DW-1:0] bus_data_o,
  output logic          bus_data_oe_o,
  input  logic          bus_iordy_i,
  output logic          rsp_done_o,
  output logic [DW-1:0] rsp_rdata_o
);
  localparam int CW = TW + MW;

  phase_e        phase;
  logic          wr, load, plus_one, accept, skip, strobe_end, zero;
  logic [TW-1:0] field;
  logic [CW-1:0] len_m1;

  cs_seq_ctrl #(.TW(TW)) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i, .cfg_en_i,
    .cfg_adr_i, .cfg_ce_i, .cfg_oe_i, .cfg_we_i, .cfg_rdhld_i,
    .cfg_wrhld_i, .cfg_pause_i, .cfg_waitm_i, .cfg_wait_i,
    .iordy_i(bus_iordy_i), .zero_i(zero),
    .phase_o(phase), .wr_o(wr), .load_o(load), .field_o(field),
    .plus_one_o(plus_one), .accept_o(accept), .skip_o(skip),
    .strobe_end_o(strobe_end)
  );

  cs_phase_len #(.TW(TW), .MW(MW)) u_len (
    .field_i(field), .plus_one_i(plus_one), .mult_i(cfg_mult_i),
    .len_m1_o(len_m1)
  );

  cs_scale_timer #(.CW(CW)) u_tmr (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(len_m1), .zero_o(zero)
  );

  cs_data_path #(.AW(AW), .DW(DW)) u_dp (
    .clk_i, .rst_ni, .accept_i(accept), .skip_i(skip),
    .strobe_end_i(strobe_end), .wr_i(wr), .addr_i(req_addr_i),
    .wdata_i(req_wdata_i), .bus_data_i, .addr_o(bus_addr_o),
    .wdata_o(bus_data_o), .rdata_o(rsp_rdata_o), .done_o(rsp_done_o)
  );

  logic ce_act, stb_act;
  always_comb begin
    ce_act  = phase inside {PH_CES, PH_STB, PH_WEXT, PH_HLD};
    stb_act = phase inside {PH_STB, PH_WEXT};
  end

  assign req_ready_o   = (phase == PH_IDLE);
  assign bus_ce_no     = !ce_act;
  assign bus_oe_no     = !(stb_act && !wr);
  assign bus_we_no     = !(stb_act && wr);
  assign bus_data_oe_o = wr && (phase inside {PH_ADR, PH_CES, PH_STB, PH_WEXT, PH_HLD});
endmodule

// File: rtl/cs_bus_seq_chk.sv
`timescale 1ns/1ps
module cs_bus_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          cfg_en_i,
  input logic [AW-1:0] bus_addr_o,
  input logic          bus_ce_no,
  input logic          bus_oe_no,
  input logic          bus_we_no,
  input logic          bus_data_oe_o,
  input logic          rsp_done_o
);
  // R11
  strobe_under_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_oe_no || !bus_we_no) |-> !bus_ce_no);
  // R11
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!bus_oe_no && !bus_we_no));
  // R6
  ce_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_ce_no |-> !req_ready_o);
  // R2
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_ce_no && $past(!bus_ce_no)) |-> $stable(bus_addr_o));
  // R2
  addr_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_ce_no) |-> $stable(bus_addr_o));
  // R4
  we_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_we_no |-> bus_data_oe_o);
  // R3
  oe_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_oe_no |-> !bus_data_oe_o);
  // R9
  disabled_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !cfg_en_i) |=> (bus_ce_no && rsp_done_o));
endmodule

bind cs_bus_seq cs_bus_seq_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o), .cfg_en_i(cfg_en_i), .bus_addr_o(bus_addr_o),
  .bus_ce_no(bus_ce_no), .bus_oe_no(bus_oe_no), .bus_we_no(bus_we_no),
  .bus_data_oe_o(bus_data_oe_o), .rsp_done_o(rsp_done_o)
);

// File: tb/cs_bus_seq_tb.sv
`timescale 1ns/1ps
module cs_bus_seq_tb;
  localparam int AW = 16, DW = 16, TW = 6, MW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid = 0, req_write = 0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          cfg_en = 1, cfg_waitm = 0;
  logic [MW-1:0] cfg_mult = 1;
  logic [TW-1:0] cfg_adr = 0, cfg_ce = 0, cfg_oe = 0, cfg_we = 0;
  logic [TW-1:0] cfg_rdhld = 0, cfg_wrhld = 0, cfg_pause = 0, cfg_wait = 0;
  logic [AW-1:0] bus_addr;
  logic          ce_n, oe_n, we_n, data_oe, done;
  logic [DW-1:0] bus_din = '0, bus_dout, rdata;
  logic          iordy = 1;

  cs_bus_seq #(.AW(AW), .DW(DW), .TW(TW), .MW(MW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .cfg_en_i(cfg_en), .cfg_mult_i(cfg_mult), .cfg_adr_i(cfg_adr), .cfg_ce_i(cfg_ce),
    .cfg_oe_i(cfg_oe), .cfg_we_i(cfg_we), .cfg_rdhld_i(cfg_rdhld),
    .cfg_wrhld_i(cfg_wrhld), .cfg_pause_i(cfg_pause), .cfg_waitm_i(cfg_waitm),
    .cfg_wait_i(cfg_wait), .bus_addr_o(bus_addr), .bus_ce_no(ce_n),
    .bus_oe_no(oe_n), .bus_we_no(we_n), .bus_data_i(bus_din),
    .bus_data_o(bus_dout), .bus_data_oe_o(data_oe), .bus_iordy_i(iordy),
    .rsp_done_o(done), .rsp_rdata_o(rdata)
  );

  int n_tests = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // measured results of one access
  int m_pre, m_ces, m_stb, m_hld, m_pau, m_other, m_dones, m_abad, m_wbad;
  logic [DW-1:0] m_rd;

  task automatic access(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [DW-1:0] rpat, input int rel);
    int ph;
    logic stb_n, oth_n;
    bus_din = rpat; req_write = wr; req_addr = a; req_wdata = d; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0; req_addr = ~a; req_wdata = ~d;
    m_pre = 0; m_ces = 0; m_stb = 0; m_hld = 0; m_pau = 0;
    m_other = 0; m_dones = 0; m_abad = 0; m_wbad = 0; m_rd = '0;
    ph = 0;
    for (int k = 0; k < 5000; k++) begin
      if (k == rel) iordy = 1;
      stb_n = wr ? we_n : oe_n;
      oth_n = wr ? oe_n : we_n;
      if (done) begin m_dones++; m_rd = rdata; end
      if (bus_addr !== a) m_abad++;
      if (!oth_n) m_other++;
      if (ph == 0 && !ce_n) ph = 1;
      if (ph == 1 && !stb_n) ph = 2;
      if (ph == 2 && stb_n) begin ph = 3; bus_din = ~rpat; end
      if (ph == 3 && ce_n) ph = 4;
      if (ph == 4 && req_ready) break;
      if (wr && ph < 4 && (!data_oe || bus_dout !== d)) m_wbad++;
      if (ph == 4 && data_oe) m_wbad++;
      case (ph)
        0: m_pre++;
        1: m_ces++;
        2: m_stb++;
        3: m_hld++;
        default: m_pau++;
      endcase
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic          wr;
    logic [TW-1:0] adr, ce, stb, hld, pau;
    logic [MW-1:0] mult;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{wr:1'b0, adr:6'd0, ce:6'd0, stb:6'd0, hld:6'd0, pau:6'd0, mult:3'd1},
    '{wr:1'b0, adr:6'd1, ce:6'd2, stb:6'd3, hld:6'd1, pau:6'd2, mult:3'd2},
    '{wr:1'b1, adr:6'd0, ce:6'd1, stb:6'd4, hld:6'd2, pau:6'd0, mult:3'd2},
    '{wr:1'b1, adr:6'd2, ce:6'd0, stb:6'd1, hld:6'd3, pau:6'd1, mult:3'd3},
    '{wr:1'b0, adr:6'd3, ce:6'd1, stb:6'd5, hld:6'd0, pau:6'd4, mult:3'd1},
    '{wr:1'b0, adr:6'd0, ce:6'd2, stb:6'd0, hld:6'd1, pau:6'd0, mult:3'd0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(ce_n && oe_n && we_n, "R10 strobes high in reset", {ce_n, oe_n, we_n}, 7);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R10 ready after reset", req_ready, 1);
    chk(!data_oe && !done, "R10 driver/done low", {data_oe, done}, 0);

    for (int i = 0; i < NV; i++) begin
      int m;
      vec_t v;
      logic [DW-1:0] rp, wd;
      v = VECS[i];
      m = (v.mult == 0) ? 1 : int'(v.mult);
      cfg_mult = v.mult; cfg_adr = v.adr; cfg_ce = v.ce;
      cfg_oe = v.wr ? v.stb + 6'd2 : v.stb;
      cfg_we = v.wr ? v.stb : v.stb + 6'd2;
      cfg_rdhld = v.wr ? v.hld + 6'd3 : v.hld;
      cfg_wrhld = v.wr ? v.hld : v.hld + 6'd3;
      cfg_pause = v.pau;
      rp = 16'hA500 + 16'(i);
      wd = 16'h5A00 ^ 16'(i * 7);
      access(v.wr, 16'h1000 + 16'(i * 3), wd, rp, -1);
      chk(m_pre == (int'(v.adr) + 1) * m, "R1 address setup length", m_pre, (int'(v.adr) + 1) * m);
      chk(m_ces == (int'(v.ce) + 1) * m, "R1 CE-to-strobe length", m_ces, (int'(v.ce) + 1) * m);
      chk(m_stb == (int'(v.stb) + 1) * m, "R1 strobe length", m_stb, (int'(v.stb) + 1) * m);
      chk(m_hld == (int'(v.hld) + 1) * m, "R5 hold length by direction", m_hld, (int'(v.hld) + 1) * m);
      chk(m_pau == (int'(v.pau) + 1) * m, "R6 pause holds off ready", m_pau, (int'(v.pau) + 1) * m);
      chk(m_other == 0, "R11 opposite strobe stays high", m_other, 0);
      chk(m_abad == 0, "R2 address held", m_abad, 0);
      chk(m_dones == 1, "R3 single done pulse", m_dones, 1);
      if (v.wr) chk(m_wbad == 0, "R4 write data driven", m_wbad, 0);
      else      chk(m_rd === rp, "R3 read data sampled at strobe end", int'(m_rd), int'(rp));
    end

    // wait mode: all fields 0, mult 2 -> setup 2, ce 2, strobe base 2
    cfg_mult = 2; cfg_adr = 0; cfg_ce = 0; cfg_oe = 0; cfg_we = 0;
    cfg_rdhld = 0; cfg_wrhld = 0; cfg_pause = 0;
    cfg_waitm = 1; cfg_wait = 0;
    @(negedge clk); iordy = 0;
    access(1'b0, 16'h2222, 16'h0, 16'h3C3C, 20);
    chk(m_stb == 17, "R7 IORDY stretches strobe", m_stb, 17);
    chk(m_rd === 16'h3C3C, "R7 read after stretch", int'(m_rd), 16'h3C3C);

    cfg_wait = 1;
    @(negedge clk); iordy = 0;
    access(1'b1, 16'h2224, 16'h7777, 16'h0, 20);
    chk(m_stb == 19, "R7 WAIT extends after IORDY", m_stb, 19);
    chk(m_wbad == 0, "R4 write data during stretch", m_wbad, 0);

    cfg_wait = 2; iordy = 1;
    access(1'b0, 16'h2226, 16'h0, 16'h1111, -1);
    chk(m_stb == 6, "R7 WAIT with IORDY high", m_stb, 6);

    // R8 wait mode off: IORDY low for the whole access is ignored
    cfg_waitm = 0; cfg_wait = 3;
    @(negedge clk); iordy = 0;
    access(1'b0, 16'h2228, 16'h0, 16'h4242, -1);
    chk(m_stb == 2, "R8 IORDY ignored when wait mode off", m_stb, 2);
    chk(m_rd === 16'h4242, "R8 read data", int'(m_rd), 16'h4242);
    iordy = 1;

    // R9 disabled region
    cfg_en = 0;
    @(negedge clk);
    chk(rdata !== 16'h0, "R9 precondition rdata nonzero", int'(rdata), 1);
    req_write = 0; req_addr = 16'h3333; req_valid = 1;
    chk(req_ready === 1'b1, "R9 ready while idle", req_ready, 1);
    @(negedge clk);
    req_valid = 0;
    chk(done === 1'b1, "R9 done next cycle", done, 1);
    chk(rdata === 16'h0, "R9 read data zero", int'(rdata), 0);
    chk(ce_n && oe_n && we_n, "R9 no strobes", {ce_n, oe_n, we_n}, 7);
    chk(req_ready === 1'b1, "R9 stays ready", req_ready, 1);
    @(negedge clk);
    chk(done === 1'b0 && ce_n, "R9 done single cycle", done, 0);
    cfg_en = 1;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule